// File: doc/BRIEF.md
# I2S Receive Capture Sequencer

This block is the front end of a slave-mode I2S receiver. It runs on the incoming bit clock, samples word select and serial data, and rebuilds each channel word in a shift register. A single enable bit decides whether finished words are handed to a downstream receive FIFO as a one-cycle write strobe with the word and a channel flag.

The enable bit does not act at once. A four-state controller moves from idle through an arming state into a running state, and back through a draining state. Every state change happens on a frame boundary, which is the falling edge of word select where a left-channel slot begins. Each pending state lasts a fixed number of whole frames. Capture therefore always starts and stops on a complete stereo frame. Software reads the controller state from a two-bit status field.

Top module: `i2s_rx_capture`

## Requirements
- R1: After a synchronous active-low reset, `status` is 2'b00 (idle) and `push` is low.
- R2: `status` encodes idle as 2'b00, arming as 2'b01, running as 2'b10 and draining as 2'b11. It changes only in the bit clock cycle after a sample where word select falls from 1 to 0 (a frame boundary).
- R3: In idle, a frame boundary sampled with `rx_en` high moves to arming. Arming lasts exactly two frames, and the second boundary after entry moves to running whatever the value of `rx_en`.
- R4: In running, a frame boundary sampled with `rx_en` low moves to draining. Draining lasts exactly two frames and then moves to idle.
- R5: No `push` occurs for a word whose frame was received in idle, arming or draining, even while serial data toggles.
- R6: In running, every channel slot of exactly WORD_W bit clocks gives one `push` pulse, one bit clock long. It comes in the cycle after the sample where word select changes at the end of that slot. `push_data` holds the WORD_W bits sampled after the slot's word-select change, MSB first, with the MSB sampled one bit clock after the change.
- R7: `push_right` is 0 for a word received while word select was 0 (left) and 1 for a word received while word select was 1 (right).
- R8: A slot whose length is not exactly WORD_W bit clocks is discarded. It gives no `push`, and the words around it are still delivered.
- R9: A change of `rx_en` during arming or draining does not cut the pending state short. The pending transition completes, and the new `rx_en` value is acted on at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ws | input | 1 | Word select: 0 for the left slot, 1 for the right slot |
| sd | input | 1 | Serial audio data, MSB first |
| rx_en | input | 1 | Capture enable bit from the control register (bit 0, reset value 0) |
| push | output | 1 | One-cycle write strobe toward the receive FIFO |
| push_data | output | WORD_W | Word written with `push` |
| push_right | output | 1 | Channel of the word written with `push` |
| status | output | 2 | Current controller state |

## Verification
A frame boundary is sampled at one rising bit-clock edge, and `status` shows the new state straight after that edge. The bench therefore checks status in the first cycle of each frame and again in its last cycle. A finished word's `push` appears one edge after the sample that carries its LSB and the next word-select change. The bench drives every input at the falling edge and reads `push`, `push_data` and `push_right` at the next falling edge for each bit. It expects a strobe only in the cycle that follows a slot end in running, and checks that `push` is low in every other cycle. A walking-one and walking-zero sweep covers every data bit position in both channels.

// File: rtl/i2s_rx_pkg.sv
// Shared types for the I2S receive capture block.
package i2s_rx_pkg;

    // Controller state; the encoding is visible to software as the status field.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMING = 2'b01,
        ST_RUN    = 2'b10,
        ST_DRAIN  = 2'b11
    } rx_state_e;

endpackage

// File: rtl/i2s_rx_deser.sv
// Serial-to-parallel word builder for an I2S slave receiver.
// Does: samples ws and sd on the rising bit clock, detects word-select changes,
//       flags frame boundaries (ws falling) and offers each finished slot word.
// Assumes: I2S framing, MSB one bit clock after the ws change, slot length equal
//          to WORD_W; a slot of any other length is reported as not done.
module i2s_rx_deser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws,
    input  logic              sd,
    output logic              frame_start,
    output logic              word_done,
    output logic [WORD_W-1:0] word_data,
    output logic              word_right
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W - 1);

    logic              ws_prev;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  slot_cnt;
    logic              ws_edge;

    // Word-select change seen in the current sample.
    assign ws_edge     = ws ^ ws_prev;
    assign frame_start = ws_edge & ws_prev;
    // A slot is complete only when exactly WORD_W samples fell inside it.
    assign word_done   = ws_edge && (slot_cnt == CNT_FULL);
    assign word_data   = {shreg[WORD_W-2:0], sd};
    assign word_right  = ws_prev;

    // Sample history, shift register and slot length counter (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev  <= 1'b0;
            shreg    <= '0;
            slot_cnt <= CNT_MAX;
        end else begin
            ws_prev <= ws;
            shreg   <= {shreg[WORD_W-2:0], sd};
            if (ws_edge)
                slot_cnt <= '0;
            else if (slot_cnt != CNT_MAX)
                slot_cnt <= slot_cnt + CNT_W'(1);
        end
    end

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

endmodule

// File: rtl/i2s_rx_seq.sv
// Enable sequencer for the I2S receiver.
// Does: moves idle -> arming -> running -> draining -> idle, changing state
//       only on frame boundaries; each pending state lasts PEND_FRAMES frames.
// Assumes: frame_start is a single-cycle flag from the deserializer.
module i2s_rx_seq
    import i2s_rx_pkg::*;
#(
    parameter int PEND_FRAMES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      frame_start,
    output rx_state_e state
);
    localparam int PEND_W = $clog2(PEND_FRAMES + 1);
    localparam logic [PEND_W-1:0] PEND_LAST = PEND_W'(PEND_FRAMES - 1);

    rx_state_e         nxt;
    logic [PEND_W-1:0] pend_cnt;
    logic              pend_last;
    logic              pending;

    assign pend_last = (pend_cnt == PEND_LAST);
    assign pending   = (state == ST_ARMING) || (state == ST_DRAIN);

    // Next-state choice, evaluated only at frame boundaries.
    always_comb begin
        nxt = state;
        if (frame_start) begin
            case (state)
                ST_IDLE:   if (en)         nxt = ST_ARMING;
                ST_ARMING: if (pend_last)  nxt = ST_RUN;
                ST_RUN:    if (!en)        nxt = ST_DRAIN;
                ST_DRAIN:  if (pend_last)  nxt = ST_IDLE;
                default:                   nxt = ST_IDLE;
            endcase
        end
    end

    // State register and count of frames spent in a pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend_cnt <= '0;
        end else begin
            state <= nxt;
            if (frame_start) begin
                if (nxt != state)
                    pend_cnt <= '0;
                else if (pending)
                    pend_cnt <= pend_cnt + PEND_W'(1);
            end
        end
    end

    // R2
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(state));

    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_ARMING));

    // R4
    run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_DRAIN));

endmodule

// File: rtl/i2s_rx_capture.sv
// I2S slave receive capture with frame-aligned enable sequencing.
// Does: builds channel words from the serial stream and writes them toward the
//       receive FIFO only while the sequencer is running.
// Assumes: everything runs in the bit clock domain; rx_en is a stable register bit.
module i2s_rx_capture
    import i2s_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PEND_FRAMES = 2
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              ws,
    input  logic              sd,
    input  logic              rx_en,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              push_right,
    output logic [1:0]        status
);
    logic              frame_start;
    logic              word_done;
    logic [WORD_W-1:0] word_data;
    logic              word_right;
    rx_state_e         st;

    i2s_rx_deser #(.WORD_W(WORD_W)) u_deser (
        .clk         (bclk),
        .rst_n       (rst_n),
        .ws          (ws),
        .sd          (sd),
        .frame_start (frame_start),
        .word_done   (word_done),
        .word_data   (word_data),
        .word_right  (word_right)
    );

    i2s_rx_seq #(.PEND_FRAMES(PEND_FRAMES)) u_seq (
        .clk         (bclk),
        .rst_n       (rst_n),
        .en          (rx_en),
        .frame_start (frame_start),
        .state       (st)
    );

    assign status = st;

    // FIFO write register: pass finished words only while running.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            push       <= 1'b0;
            push_data  <= '0;
            push_right <= 1'b0;
        end else begin
            push <= word_done && (st == ST_RUN);
            if (word_done) begin
                push_data  <= word_data;
                push_right <= word_right;
            end
        end
    end

    // R5
    push_in_run_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        push |-> ($past(st) == ST_RUN));

endmodule

// File: tb/tb_i2s_rx_capture.sv
module tb_i2s_rx_capture;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ws = 1'b0;
    logic         sd = 1'b0;
    logic         rx_en = 1'b0;
    logic         push;
    logic [W-1:0] push_data;
    logic         push_right;
    logic [1:0]   status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic         prev_bit = 1'b0;
    bit           prev_act = 1'b0;
    logic [W-1:0] prev_r = '0;

    i2s_rx_capture #(.WORD_W(W), .PEND_FRAMES(2)) dut (
        .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd), .rx_en(rx_en),
        .push(push), .push_data(push_data), .push_right(push_right), .status(status)
    );

    always #(CLK_PERIOD/2) bclk = ~bclk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int f);
        return W'(f * 40503 + 4660) ^ (W'(1) << (f % W));
    endfunction

    // One frame: left slot of llen bit clocks, right slot of W; checks each cycle.
    task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r, input logic en_v,
                             input logic [1:0] exp_st, input int llen, input string st_req);
        bit act;
        bit exp_left;
        act = (exp_st == 2'b10);
        exp_left = act && (llen == W);
        rx_en = en_v;
        for (int i = 0; i < llen + W; i++) begin
            logic cur;
            if (i < llen) cur = (i < W) ? l[W-1-i] : 1'b0;
            else          cur = r[W-1-(i-llen)];
            ws = (i >= llen);
            sd = prev_bit;
            prev_bit = cur;
            @(posedge bclk);
            @(negedge bclk);
            if (i == 0) begin
                chk(status == exp_st, st_req, 32'(status), 32'(exp_st));
                chk(push == prev_act, prev_act ? "R6 right push" : "R5 right push", 32'(push), 32'(prev_act));
                if (prev_act && push) begin
                    chk(push_data == prev_r, "R6 right data", 32'(push_data), 32'(prev_r));
                    chk(push_right == 1'b1, "R7 right flag", 32'(push_right), 32'd1);
                end
            end else if (i == llen) begin
                chk(push == exp_left, (llen != W) ? "R8 odd slot" : (act ? "R6 left push" : "R5 left push"),
                    32'(push), 32'(exp_left));
                if (exp_left && push) begin
                    chk(push_data == l, "R6 left data", 32'(push_data), 32'(l));
                    chk(push_right == 1'b0, "R7 left flag", 32'(push_right), 32'd0);
                end
            end else begin
                chk(push == 1'b0, act ? "R6 stray push" : "R5 stray push", 32'(push), 32'd0);
            end
            if (i == llen + W - 1)
                chk(status == exp_st, "R2 status held", 32'(status), 32'(exp_st));
        end
        prev_act = act;
        prev_r = r;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge bclk);
        rst_n = 1'b1;
        @(negedge bclk);
        // R1
        chk(status == 2'b00, "R1 status", 32'(status), 32'd0);
        chk(push == 1'b0, "R1 push", 32'(push), 32'd0);
        // Preamble: a right slot so the first frame boundary is seen.
        for (int i = 0; i < W; i++) begin
            ws = 1'b1;
            sd = i[0];
            @(posedge bclk);
            @(negedge bclk);
            chk(push == 1'b0, "R5 preamble", 32'(push), 32'd0);
        end
        prev_bit = 1'b0;
        // Idle with live data (R5), then arming (R3).
        run_frame(pat(0), pat(1), 1'b0, 2'b00, W, "R5 idle");
        run_frame(pat(2), pat(3), 1'b0, 2'b00, W, "R5 idle");
        run_frame(pat(4), pat(5), 1'b1, 2'b01, W, "R3 arming 1");
        run_frame(pat(6), pat(7), 1'b1, 2'b01, W, "R3 arming 2");
        run_frame(pat(8), pat(9), 1'b1, 2'b10, W, "R3 running");
        // Walking one / walking zero over every bit position (R6, R7).
        for (int k = 0; k < W; k++)
            run_frame(W'(1) << k, ~(W'(1) << k), 1'b1, 2'b10, W, "R6 running");
        // Odd slot lengths (R8).
        run_frame(pat(10), pat(11), 1'b1, 2'b10, W + 2, "R8 long slot");
        run_frame(pat(12), pat(13), 1'b1, 2'b10, W - 3, "R8 short slot");
        // Drain, with a toggle back during draining (R4, R9).
        run_frame(pat(14), pat(15), 1'b0, 2'b11, W, "R4 draining 1");
        run_frame(pat(16), pat(17), 1'b1, 2'b11, W, "R9 draining 2");
        run_frame(pat(18), pat(19), 1'b1, 2'b00, W, "R9 idle after drain");
        // Arm, toggle back during arming (R9), then drain to idle (R4).
        run_frame(pat(20), pat(21), 1'b1, 2'b01, W, "R3 arming");
        run_frame(pat(22), pat(23), 1'b0, 2'b01, W, "R9 arming held");
        run_frame(pat(24), pat(25), 1'b0, 2'b10, W, "R9 running reached");
        run_frame(pat(26), pat(27), 1'b0, 2'b11, W, "R4 draining 1");
        run_frame(pat(28), pat(29), 1'b0, 2'b11, W, "R4 draining 2");
        run_frame(pat(30), pat(31), 1'b0, 2'b00, W, "R4 idle");
        run_frame(pat(32), pat(33), 1'b0, 2'b00, W, "R5 idle flush");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule